// File: doc/BRIEF.md
# Transmit Block Count Sequencer

This block sequences an outbound block-write transfer. Software programs a 32-bit control word, a long-block mode bit, a 16-bit destination node ID and a 48-bit destination start offset, split into a 16-bit upper part and a 32-bit lower part. A start strobe then launches the transfer. The packet serialiser raises a block-sent strobe after each block leaves. The block keeps the header fields that the serialiser places in each write request: the destination node ID and the current 48-bit offset.

The mode bit sets how the control word is read. With the mode bit at 0 the word is the number of blocks still to send. The sequencer decrements it after every block, and the offset advances by a fixed per-block byte count (parameter `BLK_BYTES`). With the mode bit at 1 the word is the byte size of a single long block. That one block finishes the transfer, and the offset advances by the word itself. A bus reset pulse clears the control word and aborts any transfer in progress.

The controller has three states. `ST_IDLE` waits for work. `ST_SEND` is the transfer in progress, with busy high. `ST_DONE` lasts one cycle and raises done. The transitions are:
- `ST_IDLE`/`ST_DONE` to `ST_SEND` on an accepted start, meaning a start strobe with a nonzero control word.
- `ST_SEND` to `ST_SEND` on each block that is not the last.
- `ST_SEND` to `ST_DONE` on the last block.
- `ST_DONE` to `ST_IDLE` when no start arrives.
- Any state to `ST_IDLE` on a bus reset.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, busy and done are 0 and the control word, destination ID and current offset all read 0.
- R2: A start strobe while the control word is 0 is ignored: busy stays 0 and done stays 0.
- R3: With the mode bit at 0, each block-sent strobe during a transfer lowers the control word by one. The new value is visible the cycle after the strobe.
- R4: With the mode bit at 0, the cycle after the block-sent strobe that takes the count to 0 shows busy 0 and done 1. In the following cycle done is 0 again.
- R5: Register select 1 holds the destination ID in bits 15:0 and the upper 16 offset bits in bits 31:16. Select 2 holds the lower 32 offset bits. The destination ID output follows select 1 one cycle after a write. An accepted start sets busy and loads the current offset from the start offset, both one cycle later.
- R6: With the mode bit at 0, each block advances the 48-bit current offset by `BLK_BYTES`. A carry out of the lower 32 bits passes into the upper part.
- R7: With the mode bit (select 3, bit 0) at 1, the control word is a byte size. The first block-sent strobe ends the transfer with done, advances the offset by that size, and leaves the control word unchanged.
- R8: A bus reset pulse sets the control word to 0 one cycle later. During a transfer it also drops busy in that cycle without raising done in that cycle or the next.
- R9: While busy, writes to the control word (select 0) and to the mode bit are ignored. While idle, a control-word write takes effect one cycle later.
- R10: A block-sent strobe while idle leaves the control word, the offset, busy and done unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_reset | input | 1 | Bus reset pulse; clears the control word and aborts a transfer |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 2 | Register select: 0 control word, 1 ID/offset high, 2 offset low, 3 mode |
| reg_wdata | input | 32 | Register write data |
| start | input | 1 | Transfer start strobe |
| blk_sent | input | 1 | One block has been transmitted |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| ctl_word | output | 32 | Current control word (block count or block size) |
| dst_id | output | 16 | Destination node ID header field |
| cur_offset | output | 48 | Current destination offset header field |

## Verification
Every result of this block is registered exactly once. A write, start, block-sent strobe or bus reset driven before a rising edge is therefore seen on busy, done, the control word, the ID or the offset right after that edge. The driver tasks apply each stimulus on a falling edge and queue the full expected output vector tagged with the next cycle number. The monitor compares it a quarter period after that rising edge. For the one-cycle done pulse, the bench also queues an expectation for the cycle after it, which must show done low again.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        SEL_CTL   = 2'd0,
        SEL_DSTHI = 2'd1,
        SEL_OFFLO = 2'd2,
        SEL_MODE  = 2'd3
    } reg_sel_t;

endpackage

// File: rtl/blkxfer_regs.sv
module blkxfer_regs
    import blkxfer_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ID_W   = 16,
    localparam int HI_W  = WORD_W - ID_W,
    localparam int OFF_W = WORD_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              lock,
    input  logic              dec,
    output logic [WORD_W-1:0] ctl_word,
    output logic              long_mode,
    output logic [ID_W-1:0]   dst_id,
    output logic [OFF_W-1:0]  base_off
);

    logic [HI_W-1:0]   off_hi;
    logic [WORD_W-1:0] off_lo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_word  <= '0;
            long_mode <= 1'b0;
        end else if (bus_reset) begin
            ctl_word  <= '0;
        end else if (dec) begin
            ctl_word  <= ctl_word - 1'b1;
        end else if (wr_en && !lock) begin
            if (wr_sel == SEL_CTL)  ctl_word  <= wr_data;
            if (wr_sel == SEL_MODE) long_mode <= wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_id <= '0;
            off_hi <= '0;
            off_lo <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_DSTHI) begin
                dst_id <= wr_data[ID_W-1:0];
                off_hi <= wr_data[WORD_W-1:ID_W];
            end
            if (wr_sel == SEL_OFFLO) off_lo <= wr_data;
        end
    end

    assign base_off = {off_hi, off_lo};

    a_r8_word_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> ctl_word == '0);
    a_r3_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !bus_reset) |=> ctl_word == $past(ctl_word) - 1'b1);
    a_r9_word_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !dec && !bus_reset) |=> ($stable(ctl_word) && $stable(long_mode)));

endmodule

// File: rtl/blkxfer_offset.sv
module blkxfer_offset #(
    parameter int OFF_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [OFF_W-1:0] base,
    input  logic [OFF_W-1:0] step,
    output logic [OFF_W-1:0] cur
);

    always_ff @(posedge clk) begin
        if (!rst_n)    cur <= '0;
        else if (load) cur <= base;
        else if (adv)  cur <= cur + step;
    end

    a_r5_offset_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur == $past(base));
    a_r6_offset_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> cur == OFF_W'($past(cur) + $past(step)));

endmodule

// File: rtl/blkxfer_fsm.sv
module blkxfer_fsm
    import blkxfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic start,
    input  logic blk_sent,
    input  logic word_zero,
    input  logic last_blk,
    output logic busy,
    output logic done,
    output logic load,
    output logic adv
);

    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (bus_reset) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: state_nx = (start && !word_zero) ? ST_SEND : ST_IDLE;
                ST_SEND:          if (blk_sent && last_blk) state_nx = ST_DONE;
                default:          state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        load = 1'b0;
        adv  = 1'b0;
        unique case (state)
            ST_IDLE: load = start && !word_zero && !bus_reset;
            ST_SEND: begin
                busy = 1'b1;
                adv  = blk_sent && !bus_reset;
            end
            ST_DONE: begin
                done = 1'b1;
                load = start && !word_zero && !bus_reset;
            end
            default: ;
        endcase
    end

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r4_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && blk_sent && last_blk && !bus_reset) |=> (done && !busy));
    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!busy && !done));
    a_r2_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && word_zero) |=> !busy);

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ID_W      = 16,
    parameter int BLK_BYTES = 512,
    localparam int HI_W     = WORD_W - ID_W,
    localparam int OFF_W    = WORD_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              start,
    input  logic              blk_sent,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] ctl_word,
    output logic [ID_W-1:0]   dst_id,
    output logic [OFF_W-1:0]  cur_offset
);

    localparam logic [OFF_W-1:0] STEP_FIXED = OFF_W'(BLK_BYTES);

    logic             long_mode;
    logic [OFF_W-1:0] base_off;
    logic [OFF_W-1:0] step;
    logic             word_zero;
    logic             last_blk;
    logic             load;
    logic             adv;

    assign word_zero = (ctl_word == '0);
    assign last_blk  = long_mode || (ctl_word == WORD_W'(1));
    assign step      = long_mode ? OFF_W'(ctl_word) : STEP_FIXED;

    blkxfer_regs #(.WORD_W(WORD_W), .ID_W(ID_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .wr_en     (reg_wr),
        .wr_sel    (reg_sel),
        .wr_data   (reg_wdata),
        .lock      (busy),
        .dec       (adv && !long_mode),
        .ctl_word  (ctl_word),
        .long_mode (long_mode),
        .dst_id    (dst_id),
        .base_off  (base_off)
    );

    blkxfer_offset #(.OFF_W(OFF_W)) u_offset (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (adv),
        .base  (base_off),
        .step  (step),
        .cur   (cur_offset)
    );

    blkxfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .start     (start),
        .blk_sent  (blk_sent),
        .word_zero (word_zero),
        .last_blk  (last_blk),
        .busy      (busy),
        .done      (done),
        .load      (load),
        .adv       (adv)
    );

endmodule

// File: tb/blkxfer_seq_test.sv
`timescale 1ns/1ps
module blkxfer_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        start = 1'b0;
    logic        blk_sent = 1'b0;
    logic        busy, done;
    logic [31:0] ctl_word;
    logic [15:0] dst_id;
    logic [47:0] cur_offset;

    blkxfer_seq uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .start(start), .blk_sent(blk_sent),
        .busy(busy), .done(done), .ctl_word(ctl_word),
        .dst_id(dst_id), .cur_offset(cur_offset)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0;
    int fails = 0;

    int           q_due[$];
    string        q_req[$];
    logic [97:0]  q_val[$];

    logic        e_busy = 0, e_done = 0;
    logic [31:0] e_ctl = 0;
    logic [15:0] e_id = 0;
    logic [47:0] e_off = 0;

    task automatic push(input string req);
        q_due.push_back(cyc + 1);
        q_req.push_back(req);
        q_val.push_back({e_busy, e_done, e_ctl, e_id, e_off});
    endtask

    task automatic step_wr(input logic [1:0] sel, input logic [31:0] data, input string req);
        reg_wr = 1; reg_sel = sel; reg_wdata = data;
        push(req);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic step_start(input string req);
        start = 1; push(req); @(negedge clk); start = 0;
    endtask

    task automatic step_sent(input string req);
        blk_sent = 1; push(req); @(negedge clk); blk_sent = 0;
    endtask

    task automatic step_bus(input string req);
        bus_reset = 1; push(req); @(negedge clk); bus_reset = 0;
    endtask

    task automatic step_idle(input string req);
        push(req); @(negedge clk);
    endtask

    // monitor: compare queued expectations in their due cycle
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q_due.size() > 0 && q_due[0] <= cyc) begin
                logic [97:0] exp_v;
                logic [97:0] act_v;
                string       req;
                exp_v = q_val.pop_front();
                req   = q_req.pop_front();
                void'(q_due.pop_front());
                act_v = {busy, done, ctl_word, dst_id, cur_offset};
                tests++;
                if (act_v !== exp_v) begin
                    fails++;
                    $display("FAIL %s cycle %0d: actual busy=%b done=%b ctl=%h id=%h off=%h expected busy=%b done=%b ctl=%h id=%h off=%h",
                             req, cyc, act_v[97], act_v[96], act_v[95:64], act_v[63:48], act_v[47:0],
                             exp_v[97], exp_v[96], exp_v[95:64], exp_v[63:48], exp_v[47:0]);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout, expected end of sequence");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step_idle("R1");                                   // reset state

        // count mode, header loading, carry across the low word
        step_wr(2'd3, 32'd0, "R1");
        e_id = 16'h0123;
        step_wr(2'd1, 32'hABCD_0123, "R5");
        step_wr(2'd2, 32'hFFFF_FF00, "R5");
        e_ctl = 32'd3;
        step_wr(2'd0, 32'd3, "R9");                        // idle write accepted
        e_busy = 1; e_off = 48'hABCD_FFFF_FF00;
        step_start("R5");
        e_ctl = 32'd2; e_off = 48'hABCE_0000_0100;
        step_sent("R6");                                   // carry into high part, R3 decrement
        step_wr(2'd0, 32'd99, "R9");                       // ignored while busy
        e_ctl = 32'd1; e_off = 48'hABCE_0000_0300;
        step_sent("R3");
        e_ctl = 32'd0; e_off = 48'hABCE_0000_0500; e_busy = 0; e_done = 1;
        step_sent("R4");
        e_done = 0;
        step_idle("R4");                                   // done lasts one cycle
        step_sent("R10");                                  // idle strobe ignored
        step_start("R2");                                  // zero word start ignored
        step_idle("R2");

        // long-block mode
        step_wr(2'd3, 32'd1, "R7");
        e_ctl = 32'h1000;
        step_wr(2'd0, 32'h1000, "R7");
        e_busy = 1; e_off = 48'hABCD_FFFF_FF00;
        step_start("R7");
        e_busy = 0; e_done = 1; e_off = 48'hABCE_0000_0F00;
        step_sent("R7");
        e_done = 0;
        step_idle("R7");

        // bus reset aborting a transfer
        step_wr(2'd3, 32'd0, "R8");
        e_ctl = 32'd5;
        step_wr(2'd0, 32'd5, "R8");
        e_busy = 1; e_off = 48'hABCD_FFFF_FF00;
        step_start("R8");
        e_ctl = 32'd4; e_off = 48'hABCE_0000_0100;
        step_sent("R3");
        e_busy = 0; e_ctl = 32'd0;
        step_bus("R8");
        step_idle("R8");                                   // no late done
        e_ctl = 32'd7;
        step_wr(2'd0, 32'd7, "R9");
        e_ctl = 32'd0;
        step_bus("R8");                                    // idle bus reset clears word
        step_idle("R8");

        repeat (3) @(negedge clk);
        if (q_due.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d pending, expected 0", q_due.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule